// File: doc/BRIEF.md
# Pin Event Timestamp and Compare Unit

This unit ties a single pin to a free-running time base. A 64-bit timer counts up once per reference clock from reset. When the unit is enabled with the pin set as an input, the pin is synchronized and a high level must last a minimum number of cycles before it counts as an event. Each accepted event stores the timer value into a capture register.

When the pin is set as an output, software writes a target time. When the timer reaches that target, the unit drives a pulse of fixed width on the pin and stores the timer value into the capture register. If periodic operation is selected and the interval is nonzero, the target moves forward by the interval after each match. The unit keeps a count of events. Reading the capture register also copies that count into a snapshot register, so software can tell which event a timestamp belongs to.

Software reaches the unit through a plain register port. Reads return data one cycle after the read strobe. Register map (reg_addr): 0 control (bit 0 enable, bit 1 output direction, bit 2 periodic), 1 target time, 2 interval, 3 capture (read-only), 4 event-count snapshot (read-only), 5 live timer (read-only).

Top module: `tgpio_stamp`

## Requirements
- R1: After reset the timer is zero and then rises by one on every clock. A read of address 5 returns the timer value of the cycle in which the read strobe is high.
- R2: pin_oe is high exactly when control bit 0 (enable) and bit 1 (output) are both set. After reset pin_oe and pin_out are low and the capture and snapshot registers read zero.
- R3: In input mode with the unit enabled, the synchronized pin must be high for QUAL consecutive cycles to count as an event. The event stores the timer into capture. With the defaults, a pin held high for two clocks counts, a one-clock pulse is ignored, and the stored value is the timer at pin rise plus three.
- R4: A pin that stays high produces only one input event until it returns low.
- R5: Pin activity changes neither capture nor the event count while the unit is in output mode or disabled.
- R6: In output mode with a target written, the timer reaching the target stores the target value into capture and drives pin_out high for PW cycles, starting the cycle after the match.
- R7: With periodic mode off, a target produces one output event only.
- R8: With periodic mode on and a nonzero interval, output events repeat each interval after the first match. An interval of zero gives a single event.
- R9: Every input or output event raises the event count by one. A read of address 3 copies the event count into the snapshot register, which address 4 returns.
- R10: Writing control so that the unit is no longer enabled in output mode removes pin_out on the next cycle and cancels any pending match. Re-enabling without writing a new target produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TW | Write data |
| reg_rdata | output | TW | Read data, valid the cycle after reg_rd |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The bench uses the default parameters: a 64-bit timer, a 32-bit event count, a two-cycle qualifier and a two-cycle output pulse. Because the timer starts at zero, the bench can predict every timestamp exactly from its own cycle count. That makes the three-cycle input latency and the match-to-pulse offset checkable to the exact cycle. Wrap-around of a 64-bit timer cannot occur within the run, so the tests cover exact placement, qualifier rejection and re-arm spacing rather than overflow.

// File: rtl/tgpio_stamp.sv
module tgpio_stamp #(
  parameter int TW   = 64,
  parameter int CW   = 32,
  parameter int QUAL = 2,
  parameter int PW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe
);
  localparam int QW  = $clog2(QUAL + 1);
  localparam int PWW = $clog2(PW + 1);

  logic [TW-1:0]  timer, target, interval, capture, rmux;
  logic [CW-1:0]  evcnt, snap;
  logic           en, dir, per, armed;
  logic           s1, s2, held;
  logic [QW-1:0]  qcnt;
  logic [PWW-1:0] pcnt;

  wire wr_ctrl   = reg_wr && reg_addr == 3'd0;
  wire wr_target = reg_wr && reg_addr == 3'd1;
  wire wr_intv   = reg_wr && reg_addr == 3'd2;
  wire ctrl_off  = wr_ctrl && !(reg_wdata[0] && reg_wdata[1]);
  wire repeat_on = per && interval != '0;

  wire qual_hit = s2 && !held && qcnt == QW'(QUAL - 1);
  wire in_ev    = en && !dir && qual_hit;
  wire out_ev   = en && dir && armed && timer == target;
  wire any_ev   = in_ev || out_ev;

  assign pin_oe  = en && dir;
  assign pin_out = pcnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
      s1 <= 1'b0; s2 <= 1'b0; held <= 1'b0; qcnt <= '0;
    end else begin
      timer <= timer + TW'(1);
      s1 <= pin_in;
      s2 <= s1;
      if (!s2) begin
        qcnt <= '0;
        held <= 1'b0;
      end else if (!held) begin
        if (qcnt == QW'(QUAL - 1)) held <= 1'b1;
        else qcnt <= qcnt + QW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {per, dir, en} <= '0;
      target <= '0; interval <= '0; armed <= 1'b0; pcnt <= '0;
    end else begin
      if (wr_ctrl) {per, dir, en} <= reg_wdata[2:0];
      if (wr_intv) interval <= reg_wdata;
      if (wr_target) target <= reg_wdata;
      else if (out_ev && repeat_on) target <= target + interval;
      if (ctrl_off) armed <= 1'b0;
      else if (wr_target) armed <= 1'b1;
      else if (out_ev && !repeat_on) armed <= 1'b0;
      if (ctrl_off) pcnt <= '0;
      else if (out_ev) pcnt <= PWW'(PW);
      else if (pcnt != '0) pcnt <= pcnt - PWW'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    rmux = TW'({per, dir, en});
      3'd1:    rmux = target;
      3'd2:    rmux = interval;
      3'd3:    rmux = capture;
      3'd4:    rmux = TW'(snap);
      3'd5:    rmux = timer;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capture <= '0; evcnt <= '0; snap <= '0; reg_rdata <= '0;
    end else begin
      if (any_ev) begin
        capture <= timer;
        evcnt   <= evcnt + CW'(1);
      end
      if (reg_rd) reg_rdata <= rmux;
      if (reg_rd && reg_addr == 3'd3) snap <= evcnt;
    end
  end

  a_r1_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> timer == $past(timer) + TW'(1));
  a_r3_qualified_input: assert property (@(posedge clk) disable iff (!rst_n)
    in_ev |-> s2 && $past(s2));
  a_r6_capture_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_ev |=> capture == $past(timer));
  a_r9_count_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    evcnt != $past(evcnt) |-> evcnt == $past(evcnt) + CW'(1));
  a_r10_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe);
  generate
    if (PW >= 2) begin : g_pw
      a_r6_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_out) |=> pin_out || !pin_oe);
    end
  endgenerate
endmodule

// File: tb/tgpio_stamp_bench.sv
module tgpio_stamp_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, pin_in = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        pin_out, pin_oe;
  logic [63:0] bcyc;
  int checks = 0, errors = 0;
  longint unsigned evexp = 0;
  logic [63:0] capexp = 0;

  always #10 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) bcyc <= '0; else bcyc <= bcyc + 64'd1;

  tgpio_stamp u_tgpio_stamp (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d, output logic [63:0] t);
    reg_rd = 1'b1; reg_addr = a; t = bcyc;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input int n, output logic [63:0] t0);
    pin_in = 1'b1; t0 = bcyc;
    repeat (n) @(negedge clk);
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_cap_snap(input string req);
    logic [63:0] d, t;
    rd(3'd3, d, t); chk({req, " capture"}, d, capexp);
    rd(3'd4, d, t); chk({req, " snapshot"}, d, evexp);
  endtask

  task automatic watch(input int n, output int rises, output int highs, output logic [63:0] first);
    logic prev = pin_out;
    rises = 0; highs = 0; first = '1;
    for (int i = 0; i < n; i++) begin
      if (pin_out && !prev) begin
        if (rises == 0) first = bcyc;
        rises++;
      end
      if (pin_out) highs++;
      prev = pin_out;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [63:0] d, t;
    chk("R2 oe at reset", pin_oe, 0);
    chk("R2 out at reset", pin_out, 0);
    rd(3'd3, d, t); chk("R2 capture at reset", d, 0);
    rd(3'd4, d, t); chk("R2 snapshot at reset", d, 0);
    rd(3'd5, d, t); chk("R1 timer read", d, t);
    repeat (7) @(negedge clk);
    rd(3'd5, d, t); chk("R1 timer later", d, t);
  endtask

  task automatic t_input();
    logic [63:0] t0;
    wr(3'd0, 64'd1);
    chk("R2 oe input mode", pin_oe, 0);
    pulse(2, t0);
    evexp++; capexp = t0 + 64'd3;
    check_cap_snap("R3 two-cycle pulse");
    pulse(1, t0);
    check_cap_snap("R3 short pulse ignored");
    pulse(12, t0);
    evexp++; capexp = t0 + 64'd3;
    check_cap_snap("R4 long pulse once");
  endtask

  task automatic t_ignore();
    logic [63:0] t0;
    wr(3'd0, 64'd3);
    chk("R2 oe output mode", pin_oe, 1);
    pulse(4, t0);
    check_cap_snap("R5 pin in output mode");
    wr(3'd0, 64'd0);
    chk("R2 oe disabled", pin_oe, 0);
    pulse(4, t0);
    check_cap_snap("R5 pin while disabled");
  endtask

  task automatic t_oneshot();
    int r, h; logic [63:0] f, tg;
    wr(3'd0, 64'd3);
    tg = bcyc + 64'd30;
    wr(3'd1, tg);
    watch(100, r, h, f);
    evexp++; capexp = tg;
    chk("R6 first drive cycle", f, tg + 64'd1);
    chk("R6 pulse width", h, 2);
    chk("R7 single event", r, 1);
    check_cap_snap("R6 capture at match");
  endtask

  task automatic t_periodic();
    int r, h; logic [63:0] f, tg, b;
    wr(3'd2, 64'd12);
    wr(3'd0, 64'd7);
    tg = bcyc + 64'd20;
    wr(3'd1, tg);
    b = bcyc;
    watch(int'(tg + 64'd1 + 64'd41 - b), r, h, f);
    chk("R8 first periodic", f, tg + 64'd1);
    chk("R8 periodic count", r, 4);
    chk("R8 periodic high cycles", h, 8);
    evexp += 4; capexp = tg + 64'd36;
    wr(3'd0, 64'd0);
    watch(40, r, h, f);
    chk("R10 no events after disable", r, 0);
    check_cap_snap("R8 last periodic capture");
  endtask

  task automatic t_zero_interval();
    int r, h; logic [63:0] f, tg;
    wr(3'd2, 64'd0);
    wr(3'd0, 64'd7);
    tg = bcyc + 64'd15;
    wr(3'd1, tg);
    watch(70, r, h, f);
    evexp++; capexp = tg;
    chk("R8 zero interval single", r, 1);
    check_cap_snap("R8 zero interval capture");
  endtask

  task automatic t_disable();
    int r, h; logic [63:0] f, tg;
    wr(3'd0, 64'd3);
    tg = bcyc + 64'd10;
    wr(3'd1, tg);
    while (!pin_out && bcyc < tg + 64'd20) @(negedge clk);
    evexp++; capexp = tg;
    chk("R6 pulse started", pin_out, 1);
    wr(3'd0, 64'd0);
    chk("R10 pulse cut", pin_out, 0);
    chk("R10 oe off", pin_oe, 0);
    wr(3'd0, 64'd3);
    tg = bcyc + 64'd20;
    wr(3'd1, tg);
    wr(3'd0, 64'd0);
    wr(3'd0, 64'd3);
    watch(50, r, h, f);
    chk("R10 pending match cancelled", r, 0);
    check_cap_snap("R9 count after cancel");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_input();
    t_ignore();
    t_oneshot();
    t_periodic();
    t_zero_interval();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule